// File: doc/BRIEF.md
# Out-of-Order Commit Selector

This block decides, every clock cycle, which reorder-buffer slots retire when retirement does not have to follow program order. It looks at a window that begins at the buffer head and covers `CDEPTH` slots. Inside that window it picks, oldest first, up to `CWIDTH` entries that are safe to retire. It strobes those slots and reports how many it freed. It then moves its head pointer over every leading slot that is now retired.

A slot that retires ahead of an older, still-pending slot becomes a hole. The hole stays occupied until the head sweeps past it. The surrounding buffer owns the per-slot status bits and clears a slot's valid bit after it sees that slot's strobe.

Each safety gate can be switched off separately: older unresolved store addresses, load ordering, older unresolved branches, and older entries that may fault. A mode input selects between two policies:
- **Eager:** the block always looks for as many retirements as the width allows.
- **Lazy:** the block retires out of order only when the scarcest dispatch resource can no longer take a full dispatch group, and then only as many entries as are needed to close that gap.

Top module: `ooc_commit_select`

## Requirements
- R1: After reset the head pointer is 0, no slot is a hole, and with no valid slot no strobe is raised and the freed count is 0.
- R2: A strobe is raised only for a slot that is valid, has its completion bit set, is not a hole, and lies at window offset 0 to CDEPTH-1 from the head (modulo ENTRIES).
- R3: Unless `relax_store_load` is 1, a load that is not in-order is not strobed while an older pending slot in the window is a store whose address-resolved bit is 0.
- R4: Unless `relax_load_load` is 1, a load that is not in-order is not strobed while its order-safe bit is 0.
- R5: Unless `relax_branch` is 1, a slot that is not in-order is not strobed while an older pending slot in the window is a branch whose resolved bit is 0.
- R6: Unless `relax_fault` is 1, a slot that is not in-order is not strobed while an older pending slot in the window has its may-fault bit set.
- R7: A slot is in-order when it and every older slot in the window is a hole or valid and completed. In-order slots bypass the gates of R3 to R6, and they are never counted as older pending slots for those gates.
- R8: With `lazy_mode` = 0, the eligible slots are strobed oldest first, up to CWIDTH per cycle.
- R9: Lazy mode engages only when M = min(buffer free slots, `free_regs`, `free_lq`, `free_sq`) is below DWIDTH. Buffer free slots are ENTRIES minus the number of slots that are valid or holes. When lazy mode is selected but not engaged, only in-order slots are strobed.
- R10: When lazy mode is engaged, let N be the number of in-order eligible slots, capped at CWIDTH. The total number of strobes is min(CWIDTH, N + max(0, DWIDTH − M − N)), taken oldest first.
- R11: A strobed slot that is not in the leading run becomes a hole and is never strobed again. On the next edge the head advances by the length of the run of strobed or hole slots that starts at the head, wrapping modulo ENTRIES, and the passed holes are cleared.
- R12: `freed_count` equals the number of strobes raised in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_valid | input | ENTRIES | Slot holds a live instruction |
| entry_done | input | ENTRIES | Slot finished execution |
| entry_is_load | input | ENTRIES | Slot is a load |
| entry_is_store | input | ENTRIES | Slot is a store |
| entry_st_addr_ok | input | ENTRIES | Store address known |
| entry_is_branch | input | ENTRIES | Slot is a branch |
| entry_br_ok | input | ENTRIES | Branch resolved |
| entry_may_fault | input | ENTRIES | Slot may still raise an exception |
| entry_ld_order_ok | input | ENTRIES | Load ordering guaranteed |
| relax_store_load | input | 1 | Lift the store-address gate |
| relax_load_load | input | 1 | Lift the load-ordering gate |
| relax_branch | input | 1 | Lift the branch gate |
| relax_fault | input | 1 | Lift the exception gate |
| lazy_mode | input | 1 | 1 selects the lazy policy, 0 the eager policy |
| free_regs | input | CNT_W | Free physical registers |
| free_lq | input | CNT_W | Free load-queue entries |
| free_sq | input | CNT_W | Free store-queue entries |
| commit_strobe | output | ENTRIES | One bit per slot retired this cycle |
| freed_count | output | clog2(CWIDTH+1) | Number of strobes this cycle |
| head_ptr | output | clog2(ENTRIES) | Current head slot |

## Verification
The bench builds the block with ENTRIES=8, CWIDTH=4, CDEPTH=6 and DWIDTH=4. With a window that is shorter than the buffer, it can check both the depth limit and a head that wraps around. Eight slots let lazy mode engage through the buffer's own free count as well as through the three resource counts. Thousands of cycles of mixed loads, stores, branches and faulting entries, with random relax bits and modes, are compared against an arithmetic model kept in the bench. Hand-computed cases cover each gate, the lazy-mode budget and hole sweeping.

// File: rtl/ooc_commit_pkg.sv
package ooc_commit_pkg;

   typedef enum logic {
      SEL_EAGER = 1'b0,
      SEL_LAZY  = 1'b1
   } sel_mode_e;

   typedef struct packed {
      logic st_ld;
      logic ld_ld;
      logic br;
      logic exc;
   } relax_t;

endpackage

// File: rtl/ooc_hazard_gate.sv
module ooc_hazard_gate
   import ooc_commit_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic [DEPTH-1:0] w_valid,
   input  logic [DEPTH-1:0] w_gap,
   input  logic [DEPTH-1:0] w_done,
   input  logic [DEPTH-1:0] w_load,
   input  logic [DEPTH-1:0] w_store,
   input  logic [DEPTH-1:0] w_st_ok,
   input  logic [DEPTH-1:0] w_branch,
   input  logic [DEPTH-1:0] w_br_ok,
   input  logic [DEPTH-1:0] w_fault,
   input  logic [DEPTH-1:0] w_ld_ok,
   input  relax_t           rlx,
   output logic [DEPTH-1:0] elig,
   output logic [DEPTH-1:0] in_order
);

   logic [DEPTH:0]   live;
   logic [DEPTH:0]   st_acc;
   logic [DEPTH:0]   br_acc;
   logic [DEPTH:0]   fx_acc;
   logic [DEPTH-1:0] pend;
   logic [DEPTH-1:0] cand;
   logic [DEPTH-1:0] ooc_ok;

   assign live[0]   = 1'b1;
   assign st_acc[0] = 1'b0;
   assign br_acc[0] = 1'b0;
   assign fx_acc[0] = 1'b0;

   generate
      for (genvar k = 0; k < DEPTH; k++) begin : g_pos
         // the leading run of holes and finished slots retires in order
         assign live[k+1]   = live[k] & (w_gap[k] | (w_valid[k] & w_done[k]));
         assign in_order[k] = live[k+1] & ~w_gap[k];
         assign pend[k]     = w_valid[k] & ~w_gap[k] & ~in_order[k];
         assign cand[k]     = w_valid[k] & ~w_gap[k] & w_done[k];

         // blockers seen among older pending slots
         assign st_acc[k+1] = st_acc[k] | (pend[k] & w_store[k] & ~w_st_ok[k]);
         assign br_acc[k+1] = br_acc[k] | (pend[k] & w_branch[k] & ~w_br_ok[k]);
         assign fx_acc[k+1] = fx_acc[k] | (pend[k] & w_fault[k]);

         assign ooc_ok[k] = (~w_load[k] | ((rlx.st_ld | ~st_acc[k]) & (rlx.ld_ld | w_ld_ok[k])))
                          & (rlx.br  | ~br_acc[k])
                          & (rlx.exc | ~fx_acc[k]);

         assign elig[k] = cand[k] & (in_order[k] | ooc_ok[k]);
      end
   endgenerate

endmodule

// File: rtl/ooc_quota.sv
module ooc_quota
   import ooc_commit_pkg::*;
#(
   parameter int ENTRIES = 32,
   parameter int CWIDTH  = 4,
   parameter int DWIDTH  = 4,
   parameter int CNT_W   = 8,
   localparam int IW     = $clog2(ENTRIES),
   localparam int CW     = $clog2(CWIDTH + 1)
) (
   input  sel_mode_e     mode,
   input  logic [IW:0]   rob_free,
   input  logic [CNT_W-1:0] free_regs,
   input  logic [CNT_W-1:0] free_lq,
   input  logic [CNT_W-1:0] free_sq,
   input  logic [CW-1:0] n_io,
   output logic [CW-1:0] limit,
   output logic          engaged
);

   int scarce;
   int lim;
   int extra;

   always_comb begin
      scarce = int'(rob_free);
      if (int'(free_regs) < scarce) scarce = int'(free_regs);
      if (int'(free_lq)   < scarce) scarce = int'(free_lq);
      if (int'(free_sq)   < scarce) scarce = int'(free_sq);

      engaged = (scarce < DWIDTH);
      extra   = DWIDTH - scarce - int'(n_io);
      if (extra < 0) extra = 0;

      if (mode == SEL_EAGER)
         lim = CWIDTH;
      else if (!engaged)
         lim = int'(n_io);
      else
         lim = int'(n_io) + extra;

      if (lim > CWIDTH) lim = CWIDTH;
      limit = CW'(lim);
   end

endmodule

// File: rtl/ooc_pick.sv
module ooc_pick
   import ooc_commit_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int CWIDTH = 4,
   localparam int CW    = $clog2(CWIDTH + 1),
   localparam int DW    = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  sel_mode_e        mode,
   input  logic             engaged,
   input  logic [CW-1:0]    n_io,
   input  logic [DEPTH-1:0] elig,
   input  logic [CW-1:0]    limit,
   output logic [DEPTH-1:0] sel
);

   logic [DW-1:0] rank [DEPTH+1];

   assign rank[0] = '0;

   generate
      for (genvar k = 0; k < DEPTH; k++) begin : g_rank
         assign rank[k+1] = rank[k] + DW'(elig[k]);
         assign sel[k]    = elig[k] & (int'(rank[k]) < int'(limit));
      end
   endgenerate

   // never more than the width per cycle (R8)
   p_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sel) <= CWIDTH);

   // lazy policy while idle keeps to the in-order run (R9)
   p_lazy_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SEL_LAZY && !engaged) |-> ($countones(sel) <= int'(n_io)));

endmodule

// File: rtl/ooc_commit_select.sv
module ooc_commit_select
   import ooc_commit_pkg::*;
#(
   parameter int ENTRIES = 32,
   parameter int CWIDTH  = 4,
   parameter int CDEPTH  = 8,
   parameter int DWIDTH  = 4,
   parameter int CNT_W   = 8,
   localparam int IW     = $clog2(ENTRIES),
   localparam int CW     = $clog2(CWIDTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] entry_valid,
   input  logic [ENTRIES-1:0] entry_done,
   input  logic [ENTRIES-1:0] entry_is_load,
   input  logic [ENTRIES-1:0] entry_is_store,
   input  logic [ENTRIES-1:0] entry_st_addr_ok,
   input  logic [ENTRIES-1:0] entry_is_branch,
   input  logic [ENTRIES-1:0] entry_br_ok,
   input  logic [ENTRIES-1:0] entry_may_fault,
   input  logic [ENTRIES-1:0] entry_ld_order_ok,
   input  logic               relax_store_load,
   input  logic               relax_load_load,
   input  logic               relax_branch,
   input  logic               relax_fault,
   input  logic               lazy_mode,
   input  logic [CNT_W-1:0]   free_regs,
   input  logic [CNT_W-1:0]   free_lq,
   input  logic [CNT_W-1:0]   free_sq,
   output logic [ENTRIES-1:0] commit_strobe,
   output logic [CW-1:0]      freed_count,
   output logic [IW-1:0]      head_ptr
);

   generate
      if (CDEPTH < CWIDTH) begin : g_bad_depth
         $error("CDEPTH must be at least CWIDTH");
      end
      if (CDEPTH > ENTRIES) begin : g_bad_window
         $error("CDEPTH must not exceed ENTRIES");
      end
      if ((1 << IW) != ENTRIES || ENTRIES < 2) begin : g_bad_size
         $error("ENTRIES must be a power of two of at least 2");
      end
      if (DWIDTH < 1 || CWIDTH < 1) begin : g_bad_width
         $error("widths must be positive");
      end
   endgenerate

   logic [IW-1:0]      head_q, head_d;
   logic [ENTRIES-1:0] gap_q, gap_d;

   logic [IW-1:0]     w_idx [CDEPTH];
   logic [CDEPTH-1:0] w_valid, w_gap, w_done, w_load, w_store, w_st_ok;
   logic [CDEPTH-1:0] w_branch, w_br_ok, w_fault, w_ld_ok;
   logic [CDEPTH-1:0] elig, in_order, sel;

   relax_t     rlx;
   sel_mode_e  mode;
   logic [IW:0]   rob_free;
   logic [CW-1:0] n_io;
   logic [CW-1:0] limit;
   logic          engaged;
   int            run_len;

   assign rlx  = '{st_ld: relax_store_load, ld_ld: relax_load_load,
                   br: relax_branch, exc: relax_fault};
   assign mode = lazy_mode ? SEL_LAZY : SEL_EAGER;

   // rotate the window so offset 0 is the head
   generate
      for (genvar k = 0; k < CDEPTH; k++) begin : g_win
         assign w_idx[k]    = head_q + IW'(k);
         assign w_valid[k]  = entry_valid[w_idx[k]];
         assign w_gap[k]    = gap_q[w_idx[k]];
         assign w_done[k]   = entry_done[w_idx[k]];
         assign w_load[k]   = entry_is_load[w_idx[k]];
         assign w_store[k]  = entry_is_store[w_idx[k]];
         assign w_st_ok[k]  = entry_st_addr_ok[w_idx[k]];
         assign w_branch[k] = entry_is_branch[w_idx[k]];
         assign w_br_ok[k]  = entry_br_ok[w_idx[k]];
         assign w_fault[k]  = entry_may_fault[w_idx[k]];
         assign w_ld_ok[k]  = entry_ld_order_ok[w_idx[k]];
      end
   endgenerate

   ooc_hazard_gate #(.DEPTH(CDEPTH)) u_gate (
      .w_valid  (w_valid),
      .w_gap    (w_gap),
      .w_done   (w_done),
      .w_load   (w_load),
      .w_store  (w_store),
      .w_st_ok  (w_st_ok),
      .w_branch (w_branch),
      .w_br_ok  (w_br_ok),
      .w_fault  (w_fault),
      .w_ld_ok  (w_ld_ok),
      .rlx      (rlx),
      .elig     (elig),
      .in_order (in_order)
   );

   // occupancy and in-order supply for the lazy budget
   always_comb begin
      int occ;
      int nio;
      occ = 0;
      for (int i = 0; i < ENTRIES; i++)
         occ += int'(entry_valid[i] | gap_q[i]);
      rob_free = (IW+1)'(ENTRIES - occ);
      nio = 0;
      for (int k = 0; k < CDEPTH; k++)
         nio += int'(elig[k] & in_order[k]);
      if (nio > CWIDTH) nio = CWIDTH;
      n_io = CW'(nio);
   end

   ooc_quota #(
      .ENTRIES (ENTRIES),
      .CWIDTH  (CWIDTH),
      .DWIDTH  (DWIDTH),
      .CNT_W   (CNT_W)
   ) u_quota (
      .mode      (mode),
      .rob_free  (rob_free),
      .free_regs (free_regs),
      .free_lq   (free_lq),
      .free_sq   (free_sq),
      .n_io      (n_io),
      .limit     (limit),
      .engaged   (engaged)
   );

   ooc_pick #(.DEPTH(CDEPTH), .CWIDTH(CWIDTH)) u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode),
      .engaged (engaged),
      .n_io    (n_io),
      .elig    (elig),
      .limit   (limit),
      .sel     (sel)
   );

   // map window picks back to slots and count them
   always_comb begin
      int n;
      commit_strobe = '0;
      for (int k = 0; k < CDEPTH; k++)
         if (sel[k]) commit_strobe[w_idx[k]] = 1'b1;
      n = 0;
      for (int i = 0; i < ENTRIES; i++)
         n += int'(commit_strobe[i]);
      freed_count = CW'(n);
   end

   // head sweep over retired or hole slots
   always_comb begin
      logic go;
      go = 1'b1;
      run_len = 0;
      for (int k = 0; k < CDEPTH; k++) begin
         if (go && (w_gap[k] || sel[k])) run_len++;
         else go = 1'b0;
      end
      head_d = head_q + IW'(run_len);
      for (int i = 0; i < ENTRIES; i++) begin
         logic [IW-1:0] off;
         off = IW'(i) - head_q;
         gap_d[i] = (gap_q[i] | commit_strobe[i]) & ~(int'(off) < run_len);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         gap_q  <= '0;
      end else begin
         head_q <= head_d;
         gap_q  <= gap_d;
      end
   end

   assign head_ptr = head_q;

   // strobes only on finished live slots (R2)
   p_done_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_strobe & ~(entry_valid & entry_done)) == '0);

   // a hole is never retired twice (R11)
   p_no_gap_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_strobe & gap_q) == '0);

   // nothing retiring at the head and no hole there keeps the head still (R11)
   p_head_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit_strobe[head_q] && !gap_q[head_q]) |=> $stable(head_ptr));

   // freed count tracks strobes (R12)
   p_freed_r12: assert property (@(posedge clk) disable iff (!rst_n)
      int'(freed_count) == $countones(commit_strobe));

endmodule

// File: tb/ooc_commit_select_test.sv
`timescale 1ns/1ps
module ooc_commit_select_test;

   localparam int E   = 8;
   localparam int CWD = 4;
   localparam int DEP = 6;
   localparam int DSP = 4;
   localparam int CNW = 4;
   localparam int IW  = 3;
   localparam int CW  = 3;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n;
   logic [E-1:0] v, dn, ld, st, sa, br, bo, mf, lo;
   logic rs, rl, rb, rx, lazy;
   logic [CNW-1:0] fr, fl, fs;
   logic [E-1:0]  strobe;
   logic [CW-1:0] freed;
   logic [IW-1:0] head;

   int checks = 0;
   int fails  = 0;
   logic [IW-1:0] m_head, m_tail;
   logic [E-1:0]  m_gap;

   ooc_commit_select #(
      .ENTRIES (E), .CWIDTH (CWD), .CDEPTH (DEP), .DWIDTH (DSP), .CNT_W (CNW)
   ) uut (
      .clk (clk), .rst_n (rst_n),
      .entry_valid (v), .entry_done (dn), .entry_is_load (ld),
      .entry_is_store (st), .entry_st_addr_ok (sa), .entry_is_branch (br),
      .entry_br_ok (bo), .entry_may_fault (mf), .entry_ld_order_ok (lo),
      .relax_store_load (rs), .relax_load_load (rl), .relax_branch (rb),
      .relax_fault (rx), .lazy_mode (lazy),
      .free_regs (fr), .free_lq (fl), .free_sq (fs),
      .commit_strobe (strobe), .freed_count (freed), .head_ptr (head)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clear_all();
      v = '0; dn = '0; ld = '0; st = '0; sa = '0; br = '0; bo = '0;
      mf = '0; lo = '0; rs = 0; rl = 0; rb = 0; rx = 0; lazy = 0;
      fr = 15; fl = 15; fs = 15;
   endtask

   task automatic do_reset();
      rst_n = 0;
      clear_all();
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      m_head = '0; m_gap = '0; m_tail = '0;
   endtask

   // bench model of the head sweep for a given strobe vector
   task automatic model_advance(input logic [E-1:0] s);
      int run;
      run = 0;
      for (int k = 0; k < DEP; k++) begin
         int idx;
         idx = (int'(m_head) + k) % E;
         if (m_gap[idx] || s[idx]) run++;
         else break;
      end
      m_gap = m_gap | s;
      for (int k = 0; k < run; k++) m_gap[(int'(m_head) + k) % E] = 1'b0;
      m_head = IW'((int'(m_head) + run) % E);
   endtask

   // called in the low phase with inputs set; ends at the next low phase
   task automatic step(input string tag, input logic [E-1:0] exp_s);
      logic [E-1:0] got;
      #1;
      got = strobe;
      chk({tag, " strobe"}, int'(strobe), int'(exp_s));
      chk({"R12 freed ", tag}, int'(freed), $countones(exp_s));
      model_advance(exp_s);
      @(posedge clk);
      #1;
      chk({"R11 head ", tag}, int'(head), int'(m_head));
      v = v & ~got;
      @(negedge clk);
   endtask

   function automatic logic [E-1:0] ref_pick();
      logic [E-1:0] res;
      logic prefix, bst, bbr, bfx;
      int occ, sc, nio, lim, extra, taken;
      logic [DEP-1:0] ok, io;
      res = '0;
      occ = 0;
      for (int i = 0; i < E; i++) if (v[i] || m_gap[i]) occ++;
      sc = E - occ;
      if (fr < sc) sc = fr;
      if (fl < sc) sc = fl;
      if (fs < sc) sc = fs;
      prefix = 1; bst = 0; bbr = 0; bfx = 0; nio = 0;
      for (int k = 0; k < DEP; k++) begin
         int i;
         logic live_slot;
         i = (int'(m_head) + k) % E;
         live_slot = v[i] && !m_gap[i];
         if (!(m_gap[i] || (v[i] && dn[i]))) prefix = 0;
         io[k] = prefix && !m_gap[i];
         ok[k] = 0;
         if (live_slot && dn[i]) begin
            if (io[k]) ok[k] = 1;
            else ok[k] = (!ld[i] || ((rs || !bst) && (rl || lo[i])))
                         && (rb || !bbr) && (rx || !bfx);
         end
         if (ok[k] && io[k]) nio++;
         if (live_slot && !io[k]) begin
            if (st[i] && !sa[i]) bst = 1;
            if (br[i] && !bo[i]) bbr = 1;
            if (mf[i]) bfx = 1;
         end
      end
      if (nio > CWD) nio = CWD;
      if (!lazy) lim = CWD;
      else if (sc >= DSP) lim = nio;
      else begin
         extra = DSP - sc - nio;
         if (extra < 0) extra = 0;
         lim = nio + extra;
         if (lim > CWD) lim = CWD;
      end
      taken = 0;
      for (int k = 0; k < DEP; k++)
         if (ok[k] && taken < lim) begin
            res[(int'(m_head) + k) % E] = 1'b1;
            taken++;
         end
      return res;
   endfunction

   initial begin
      #1_000_000;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      do_reset();
      // R1: reset state
      #1;
      chk("R1 head", int'(head), 0);
      chk("R1 strobe", int'(strobe), 0);
      chk("R1 freed", int'(freed), 0);
      @(negedge clk);

      // R2: only finished slots
      do_reset(); v = 8'h0F; dn = 8'h0A;
      step("R2 done", 8'h0A);
      // R2: depth limit
      do_reset(); v = 8'hFF; dn = 8'hC0;
      step("R2 depth", 8'h00);

      // R3: store address gate
      do_reset(); v = 8'h03; st[0] = 1; ld[1] = 1; lo[1] = 1; dn[1] = 1;
      step("R3 blocked", 8'h00);
      do_reset(); v = 8'h03; st[0] = 1; ld[1] = 1; lo[1] = 1; dn[1] = 1; rs = 1;
      step("R3 relaxed", 8'h02);
      do_reset(); v = 8'h03; st[0] = 1; sa[0] = 1; ld[1] = 1; lo[1] = 1; dn[1] = 1;
      step("R3 resolved", 8'h02);

      // R4: load ordering gate
      do_reset(); v = 8'h03; ld[1] = 1; dn[1] = 1;
      step("R4 blocked", 8'h00);
      do_reset(); v = 8'h03; ld[1] = 1; dn[1] = 1; rl = 1;
      step("R4 relaxed", 8'h02);

      // R5: branch gate
      do_reset(); v = 8'h03; br[0] = 1; dn[1] = 1;
      step("R5 blocked", 8'h00);
      do_reset(); v = 8'h03; br[0] = 1; dn[1] = 1; rb = 1;
      step("R5 relaxed", 8'h02);

      // R6: exception gate
      do_reset(); v = 8'h03; mf[0] = 1; dn[1] = 1;
      step("R6 blocked", 8'h00);
      do_reset(); v = 8'h03; mf[0] = 1; dn[1] = 1; rx = 1;
      step("R6 relaxed", 8'h02);

      // R7: in-order run bypasses gates
      do_reset(); v = 8'h03; dn = 8'h03; ld[0] = 1; mf[0] = 1; br[0] = 1; mf[1] = 1;
      step("R7 in-order", 8'h03);

      // R8: eager oldest-first up to width
      do_reset(); v = 8'hFF; dn = 8'hFE;
      step("R8 eager", 8'h1E);

      // R9: lazy idle
      do_reset(); v = 8'h0F; dn = 8'h0E; lazy = 1;
      step("R9 lazy idle", 8'h00);

      // R10: lazy budget cases
      do_reset(); v = 8'h3F; dn = 8'h3D; lazy = 1;
      step("R10 buffer short", 8'h05);
      do_reset(); v = 8'h0F; dn = 8'h0E; lazy = 1; fr = 1;
      step("R10 regs 1", 8'h0E);
      do_reset(); v = 8'h0F; dn = 8'h0E; lazy = 1; fr = 3;
      step("R10 regs 3", 8'h02);
      do_reset(); v = 8'h0F; dn = 8'h0E; lazy = 1; fs = 0;
      step("R10 sq 0", 8'h0E);

      // R11: holes swept by head
      do_reset(); v = 8'h0F; dn = 8'h06;
      step("R11 hole make", 8'h06);
      chk("R11 head held", int'(head), 0);
      dn[0] = 1;
      step("R11 hole sweep", 8'h01);
      chk("R11 head past holes", int'(head), 3);
      // R11: wrap around
      do_reset(); v = 8'h3F; dn = 8'h3F;
      step("R11 wrap a", 8'h0F);
      step("R11 wrap b", 8'h30);
      v = 8'hC3; dn = 8'hC3;
      step("R11 wrap c", 8'hC3);
      chk("R11 wrapped head", int'(head), 2);

      // sweep against the model: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12
      do_reset();
      for (int cyc = 0; cyc < 4000; cyc++) begin
         for (int a = 0; a < 2; a++) begin
            if (!v[m_tail] && !m_gap[m_tail]) begin
               int ty;
               ty = int'($urandom % 4);
               v[m_tail]  = 1; dn[m_tail] = 0;
               ld[m_tail] = (ty == 1); st[m_tail] = (ty == 2); br[m_tail] = (ty == 3);
               sa[m_tail] = ($urandom % 2) == 0; bo[m_tail] = ($urandom % 2) == 0;
               lo[m_tail] = ($urandom % 2) == 0; mf[m_tail] = ($urandom % 3) == 0;
               m_tail = m_tail + 1'b1;
            end
         end
         for (int i = 0; i < E; i++) begin
            if (v[i]) begin
               if (!dn[i] && ($urandom % 3) == 0) dn[i] = 1;
               if (($urandom % 4) == 0) sa[i] = 1;
               if (($urandom % 4) == 0) bo[i] = 1;
               if (($urandom % 4) == 0) lo[i] = 1;
               if (($urandom % 5) == 0) mf[i] = 0;
            end
         end
         rs = ($urandom % 4) == 0; rl = ($urandom % 4) == 0;
         rb = ($urandom % 4) == 0; rx = ($urandom % 4) == 0;
         lazy = ($urandom % 2) == 0;
         fr = CNW'($urandom % 8); fl = CNW'($urandom % 8); fs = CNW'($urandom % 8);
         step("R10 sweep", ref_pick());
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule